// File: doc/BRIEF.md
# Operand Effective Address Unit

This block turns a 6-bit operand specifier into either a register selection or a final memory address, for use by an instruction engine. The specifier gives an addressing mode and a register number. The block reads and updates an external 8-entry, 16-bit register file through one read port and one write port. When a mode needs a memory read, the block fetches the word over a simple valid/ready read port. Such a read is either an index displacement taken from the instruction stream at the program counter, or an indirect pointer.

A caller pulses `start_i` with the specifier and a byte/word flag. The block then works through its sequence and ends with one of two one-cycle strobes:
- `done_o`, with the result on `ea_o` or `reg_dir_o`;
- `align_err_o`, when a word operand resolves to an odd address.

The block performs pre-decrement and post-increment on the selected register. The step size depends on the operand size, on whether the mode is indirect, and on which register is chosen. Register 6 serves as the stack pointer and register 7 as the program counter. Immediate, absolute and PC-relative operands therefore come out of the ordinary modes applied to register 7.

Top module: `opnd_ea_unit`

## Requirements
- R1: `spec_i[5:3]` is the mode and `spec_i[2:0]` the register. The modes are:
  - 0: register direct;
  - 1: register indirect;
  - 2: post-increment;
  - 3: post-increment indirect;
  - 4: pre-decrement;
  - 5: pre-decrement indirect;
  - 6: indexed;
  - 7: indexed indirect.

  In mode 0 the block raises `done_o` with `reg_dir_o`=1 and `reg_sel_o` equal to the register. It makes no memory read and no register write.
- R2: In mode 1, `ea_o` equals the register value and the register is left unchanged.
- R3: In modes 2 and 3, the address is the register's value before the update, and the register is then increased by the step.
- R4: In modes 4 and 5, the register is decreased by the step first, and the new value is the address.
- R5: The step is 1 only for a byte operation (`byte_i`=1) in mode 2 or 4 on registers 0 to 5. It is 2 in every other case: word operations, modes 3 and 5, register 6 and register 7.
- R6: In modes 6 and 7, the block reads one word at the current value of register 7 and then adds 2 to register 7. The address is the selected register plus that word. When the selected register is 7, the advanced value is used.
- R7: In modes 3, 5 and 7, the block makes one further read at the address computed so far, and the word returned becomes `ea_o`.
- R8: Once `mem_req_o` is high, it stays high with `mem_addr_o` unchanged until a cycle in which `mem_ready_i` is high. The data is taken in that cycle.
- R9: If the final address is odd on a word operation in modes 1 to 7, the block pulses `align_err_o` instead of `done_o`. Byte operations and mode 0 never raise it.
- R10: `start_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin resolving an operand (sampled while idle) |
| spec_i | input | 6 | Mode in [5:3], register in [2:0] |
| byte_i | input | 1 | 1 = byte operation, 0 = word operation |
| busy_o | output | 1 | Sequence in progress |
| rf_raddr_o | output | 3 | Register file read index |
| rf_rdata_i | input | 16 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 3 | Register file write index |
| rf_wdata_o | output | 16 | Register file write data |
| mem_req_o | output | 1 | Memory read request valid |
| mem_addr_o | output | 16 | Memory read address |
| mem_ready_i | input | 1 | Memory accepts the request; data valid this cycle |
| mem_rdata_i | input | 16 | Memory read data |
| done_o | output | 1 | One-cycle completion strobe |
| align_err_o | output | 1 | One-cycle strobe: odd address on a word operation |
| ea_o | output | 16 | Final effective address |
| reg_dir_o | output | 1 | Operand is a register |
| reg_sel_o | output | 3 | Register selected by the specifier |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a register write-back and a memory read. This happens in modes 6 and 7 on register 7. The program counter advances in the very cycle the displacement is accepted, and the sum that follows must use the advanced value. In mode 3 on register 7, the post-increment and the indirect read touch the same register. The bench provokes these cases with directed operations on register 7. It judges them by comparing its own model of the register file after the operation, and the logged read addresses, with values computed from the requirements.

The second pair is a new `start_i` pulse and an operation still in flight. The bench pulses start while busy and checks that neither the result nor the registers change, and that no second completion follows.

// File: rtl/opnd_ea_pkg.sv
package opnd_ea_pkg;

  typedef enum logic [2:0] {
    AM_REG     = 3'd0,
    AM_REG_DEF = 3'd1,
    AM_INC     = 3'd2,
    AM_INC_DEF = 3'd3,
    AM_DEC     = 3'd4,
    AM_DEC_DEF = 3'd5,
    AM_IDX     = 3'd6,
    AM_IDX_DEF = 3'd7
  } addr_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REG,
    ST_DISP,
    ST_SUM,
    ST_PTR,
    ST_FIN
  } ea_state_e;

  function automatic logic mode_is_indirect(addr_mode_e m);
    return (m == AM_INC_DEF) || (m == AM_DEC_DEF) || (m == AM_IDX_DEF);
  endfunction

endpackage

// File: rtl/ea_step_sel.sv
module ea_step_sel
  import opnd_ea_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  addr_mode_e    mode_i,
  input  logic [RW-1:0] reg_i,
  input  logic          byte_i,
  output logic [DW-1:0] step_o
);
  localparam int SP_IDX = NREG - 2;

  logic unit_step;

  // stack pointer and program counter always move by a whole word
  assign unit_step = byte_i && !mode_is_indirect(mode_i) && (int'(reg_i) < SP_IDX);
  assign step_o    = unit_step ? DW'(1) : DW'(2);

  p_step_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == DW'(1)) || (step_o == DW'(2)));

  p_wide_regs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(reg_i) >= SP_IDX) |-> (step_o == DW'(2)));

endmodule

// File: rtl/ea_align_chk.sv
module ea_align_chk #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fin_i,
  input  logic          reg_dir_i,
  input  logic          byte_i,
  input  logic [DW-1:0] addr_i,
  output logic          done_o,
  output logic          align_err_o
);
  logic misaligned;

  assign misaligned  = !reg_dir_i && !byte_i && addr_i[0];
  assign done_o      = fin_i && !misaligned;
  assign align_err_o = fin_i && misaligned;

  p_strobe_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && align_err_o));

  p_err_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> (!byte_i && !reg_dir_i && addr_i[0]));

  p_strobe_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || align_err_o) |=> !(done_o || align_err_o));

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import opnd_ea_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG),
  localparam int SW  = 3 + RW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [SW-1:0] spec_i,
  input  logic          byte_i,
  input  logic [DW-1:0] step_i,
  output addr_mode_e    mode_o,
  output logic [RW-1:0] reg_o,
  output logic          byte_o,
  output logic          busy_o,
  output logic [RW-1:0] rf_raddr_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          fin_o,
  output logic [DW-1:0] addr_o,
  output logic          reg_dir_o
);
  localparam int SP_IDX = NREG - 2;
  localparam int PC_IDX = NREG - 1;
  localparam logic [RW-1:0] PC_SEL = RW'(PC_IDX);

  ea_state_e     state_q, state_d;
  addr_mode_e    mode_q;
  logic [RW-1:0] reg_q;
  logic          byte_q;
  logic          regdir_q;
  logic [DW-1:0] addr_q;
  logic [DW-1:0] disp_q;

  logic          is_inc, is_dec, mem_fire;
  logic [DW-1:0] reg_plus, reg_minus;

  assign is_inc    = (mode_q == AM_INC) || (mode_q == AM_INC_DEF);
  assign is_dec    = (mode_q == AM_DEC) || (mode_q == AM_DEC_DEF);
  assign reg_plus  = rf_rdata_i + step_i;
  assign reg_minus = rf_rdata_i - step_i;
  assign mem_fire  = mem_req_o && mem_ready_i;

  assign mode_o    = mode_q;
  assign reg_o     = reg_q;
  assign byte_o    = byte_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign fin_o     = (state_q == ST_FIN);
  assign addr_o    = addr_q;
  assign reg_dir_o = regdir_q;

  // datapath steering
  always_comb begin
    rf_raddr_o = reg_q;
    rf_we_o    = 1'b0;
    rf_waddr_o = reg_q;
    rf_wdata_o = reg_plus;
    mem_req_o  = 1'b0;
    mem_addr_o = addr_q;
    unique case (state_q)
      ST_REG: begin
        rf_we_o    = is_inc || is_dec;
        rf_wdata_o = is_dec ? reg_minus : reg_plus;
      end
      ST_DISP: begin
        rf_raddr_o = PC_SEL;
        rf_waddr_o = PC_SEL;
        mem_req_o  = 1'b1;
        mem_addr_o = rf_rdata_i;
        rf_we_o    = mem_ready_i;
        rf_wdata_o = rf_rdata_i + DW'(2);
      end
      ST_PTR: mem_req_o = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_REG;
      ST_REG: begin
        unique case (mode_q)
          AM_REG, AM_REG_DEF, AM_INC, AM_DEC: state_d = ST_FIN;
          AM_INC_DEF, AM_DEC_DEF:             state_d = ST_PTR;
          default:                            state_d = ST_DISP;
        endcase
      end
      ST_DISP: if (mem_ready_i) state_d = ST_SUM;
      ST_SUM:  state_d = (mode_q == AM_IDX_DEF) ? ST_PTR : ST_FIN;
      ST_PTR:  if (mem_ready_i) state_d = ST_FIN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mode_q   <= AM_REG;
      reg_q    <= '0;
      byte_q   <= 1'b0;
      regdir_q <= 1'b0;
      addr_q   <= '0;
      disp_q   <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q   <= addr_mode_e'(spec_i[SW-1 -: 3]);
          reg_q    <= spec_i[RW-1:0];
          byte_q   <= byte_i;
          regdir_q <= 1'b0;
        end
        ST_REG: begin
          regdir_q <= (mode_q == AM_REG);
          addr_q   <= is_dec ? reg_minus : rf_rdata_i;
        end
        ST_DISP: if (mem_ready_i) disp_q <= mem_rdata_i;
        ST_SUM:  addr_q <= rf_rdata_i + disp_q;
        ST_PTR:  if (mem_ready_i) addr_q <= mem_rdata_i;
        default: ;
      endcase
    end
  end

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_pc_word_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && rf_waddr_o == PC_SEL) |->
      ((rf_wdata_o == rf_rdata_i + DW'(2)) || (rf_wdata_o == rf_rdata_i - DW'(2))));

  p_sp_word_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && rf_waddr_o == RW'(SP_IDX)) |->
      ((rf_wdata_o == rf_rdata_i + DW'(2)) || (rf_wdata_o == rf_rdata_i - DW'(2))));

  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(mode_q) && $stable(reg_q) && $stable(byte_q)));

  p_regdir_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mode_q == AM_REG) |-> (!mem_req_o && !rf_we_o));

  p_mem_fire_state_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_fire |-> (mode_q >= AM_INC_DEF) && (mode_q != AM_DEC));

endmodule

// File: rtl/opnd_ea_unit.sv
module opnd_ea_unit
  import opnd_ea_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG),
  localparam int SW  = 3 + RW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [SW-1:0] spec_i,
  input  logic          byte_i,
  output logic          busy_o,
  output logic [RW-1:0] rf_raddr_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          align_err_o,
  output logic [DW-1:0] ea_o,
  output logic          reg_dir_o,
  output logic [RW-1:0] reg_sel_o
);
  addr_mode_e    mode;
  logic [RW-1:0] reg_idx;
  logic          byte_op;
  logic [DW-1:0] step;
  logic          fin;

  ea_ctrl #(.DW(DW), .NREG(NREG)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .spec_i      (spec_i),
    .byte_i      (byte_i),
    .step_i      (step),
    .mode_o      (mode),
    .reg_o       (reg_idx),
    .byte_o      (byte_op),
    .busy_o      (busy_o),
    .rf_raddr_o  (rf_raddr_o),
    .rf_rdata_i  (rf_rdata_i),
    .rf_we_o     (rf_we_o),
    .rf_waddr_o  (rf_waddr_o),
    .rf_wdata_o  (rf_wdata_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .fin_o       (fin),
    .addr_o      (ea_o),
    .reg_dir_o   (reg_dir_o)
  );

  ea_step_sel #(.DW(DW), .NREG(NREG)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .reg_i  (reg_idx),
    .byte_i (byte_op),
    .step_o (step)
  );

  ea_align_chk #(.DW(DW)) u_align (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fin_i       (fin),
    .reg_dir_i   (reg_dir_o),
    .byte_i      (byte_op),
    .addr_i      (ea_o),
    .done_o      (done_o),
    .align_err_o (align_err_o)
  );

  assign reg_sel_o = reg_idx;

endmodule

// File: tb/opnd_ea_unit_test.sv
module opnd_ea_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  spec = '0;
  logic        byte_op = 1'b0;
  logic        busy;
  logic [2:0]  rf_raddr, rf_waddr, reg_sel;
  logic [15:0] rf_rdata, rf_wdata, mem_addr, mem_rdata, ea;
  logic        rf_we, mem_req, mem_ready = 1'b0, done, aerr, reg_dir;

  logic [15:0] regs [8];
  logic [15:0] rd_log [4];
  int          rd_n = 0;
  int          tests = 0, fails = 0;
  int          ready_pct = 60;
  logic        pend = 1'b0;
  logic [15:0] pend_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mval(logic [15:0] a);
    return {a[6:0], a[15:7]} ^ 16'h3c5a;
  endfunction

  assign rf_rdata  = regs[rf_raddr];
  assign mem_rdata = mval(mem_addr);

  opnd_ea_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .spec_i(spec), .byte_i(byte_op),
    .busy_o(busy), .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .done_o(done), .align_err_o(aerr), .ea_o(ea), .reg_dir_o(reg_dir), .reg_sel_o(reg_sel)
  );

  always @(posedge clk) begin
    if (rf_we) regs[rf_waddr] <= rf_wdata;
    if (mem_req && mem_ready) begin
      if (rd_n < 4) rd_log[rd_n] <= mem_addr;
      rd_n <= rd_n + 1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R8: request hold, and random ready
  always @(negedge clk) begin
    if (rst_n && pend) begin
      check("R8", {mem_req, mem_addr}, {1'b1, pend_addr}, "request held");
    end
    mem_ready = (($urandom % 100) < ready_pct);
    pend      = rst_n && mem_req && !mem_ready;
    pend_addr = mem_addr;
  end

  // runs one operation; poke: pulse start again while busy (R10)
  task automatic run_op(logic [2:0] m, logic [2:0] r, logic b, bit poke, string req);
    logic [15:0] er [8];
    logic [15:0] exp_ea, p, d;
    logic [15:0] xr [2];
    int          xn = 0;
    int          step, waitc;
    logic        exp_dir, exp_err;
    for (int i = 0; i < 8; i++) er[i] = regs[i];
    step = (b && !(m == 3 || m == 5) && r < 6) ? 1 : 2;
    exp_dir = (m == 0);
    exp_ea  = 16'h0;
    case (m)
      0: exp_ea = 16'h0;
      1: exp_ea = er[r];
      2: begin exp_ea = er[r]; er[r] = er[r] + 16'(step); end
      3: begin p = er[r]; er[r] = er[r] + 16'd2; xr[xn++] = p; exp_ea = mval(p); end
      4: begin er[r] = er[r] - 16'(step); exp_ea = er[r]; end
      5: begin er[r] = er[r] - 16'd2; xr[xn++] = er[r]; exp_ea = mval(er[r]); end
      default: begin
        xr[xn++] = er[7];
        d = mval(er[7]);
        er[7] = er[7] + 16'd2;
        p = er[r] + d;
        if (m == 6) exp_ea = p;
        else begin xr[xn++] = p; exp_ea = mval(p); end
      end
    endcase
    exp_err = !exp_dir && !b && exp_ea[0];

    @(negedge clk);
    rd_n = 0;
    start = 1'b1; spec = {m, r}; byte_op = b;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      start = 1'b1; spec = {3'd1, r ^ 3'd1}; byte_op = ~b;
    end
    waitc = 0;
    while (!(done || aerr) && waitc < 200) begin
      @(negedge clk);
      start = 1'b0;
      waitc++;
    end
    start = 1'b0;
    check(req, 32'(waitc < 200), 1, "completion");
    check(exp_err ? "R9" : req, {done, aerr}, {!exp_err, exp_err}, "strobes");
    if (exp_dir) begin
      check("R1", {reg_dir, reg_sel}, {1'b1, r}, "register direct");
    end else begin
      check(req, reg_dir, 1'b0, "not register");
      check(req, ea, exp_ea, "address");
    end
    for (int i = 0; i < 8; i++) check(req, regs[i], er[i], $sformatf("reg %0d", i));
    check(m == 0 ? "R1" : "R7", rd_n, xn, "read count");
    for (int i = 0; i < xn && i < rd_n; i++) check(req, rd_log[i], xr[i], "read address");
    if (poke) begin
      @(negedge clk); @(negedge clk);
      check("R10", {busy, done, aerr}, 3'b000, "no second operation");
      for (int i = 0; i < 8; i++) check("R10", regs[i], er[i], "regs untouched");
    end
  endtask

  task automatic seed_regs();
    for (int i = 0; i < 8; i++) regs[i] = 16'($urandom);
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        while (wd < 150000) begin @(posedge clk); wd++; end
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) regs[i] = 16'h0100 + 16'(i * 16);
    repeat (3) @(negedge clk);
    check("R1", {busy, done, aerr, mem_req, rf_we}, 5'b0, "reset state");
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner cases
    run_op(3'd0, 3'd2, 1'b0, 0, "R1");
    run_op(3'd1, 3'd3, 1'b0, 0, "R2");
    run_op(3'd2, 3'd1, 1'b1, 0, "R5");   // byte post-inc by 1
    run_op(3'd4, 3'd0, 1'b1, 0, "R5");   // byte pre-dec by 1
    run_op(3'd2, 3'd6, 1'b1, 0, "R5");   // stack pointer by 2
    run_op(3'd4, 3'd6, 1'b1, 0, "R5");
    run_op(3'd2, 3'd7, 1'b1, 0, "R5");   // immediate on byte
    run_op(3'd3, 3'd7, 1'b0, 0, "R7");   // absolute
    run_op(3'd3, 3'd2, 1'b1, 0, "R5");   // indirect step 2 on byte
    run_op(3'd2, 3'd4, 1'b0, 0, "R3");
    run_op(3'd4, 3'd5, 1'b0, 0, "R4");
    run_op(3'd6, 3'd7, 1'b0, 0, "R6");   // PC-relative uses advanced PC
    run_op(3'd7, 3'd7, 1'b0, 0, "R6");
    run_op(3'd6, 3'd3, 1'b1, 0, "R6");
    run_op(3'd5, 3'd1, 1'b0, 0, "R7");
    regs[4] = 16'h2001;
    run_op(3'd1, 3'd4, 1'b0, 0, "R9");   // odd word address
    regs[4] = 16'h2001;
    run_op(3'd1, 3'd4, 1'b1, 0, "R9");   // odd byte address accepted
    regs[5] = 16'h0011;
    run_op(3'd0, 3'd5, 1'b0, 0, "R9");   // register direct never errors
    ready_pct = 15;
    run_op(3'd7, 3'd2, 1'b0, 1, "R10");
    run_op(3'd6, 3'd7, 1'b0, 0, "R8");
    ready_pct = 60;

    // constrained random
    for (int n = 0; n < 300; n++) begin
      logic [2:0] m, r;
      m = 3'($urandom);
      r = 3'($urandom);
      if (n % 4 == 0) seed_regs();
      ready_pct = 20 + int'($urandom % 81);
      run_op(m, r, 1'($urandom), (n % 37) == 5, m == 0 ? "R1" : (m < 4 ? "R3" : (m < 6 ? "R4" : "R6")));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule